// File: doc/BRIEF.md
# Dual-Mode DAC Input Register Front End

This block is the digital front end of a 16-bit digital-to-analog converter. A 16-bit code is built up in a first-rank holding register in one of two ways. In serial mode the code arrives one bit per chip-select strobe on a single data line. In byte mode it arrives as two 8-bit halves over a small parallel bus. A level-sensitive load input then copies the holding register into the second-rank DAC register, which drives the converter. A clear input forces the DAC register to unipolar zero or to bipolar (mid-scale) zero. The holding register keeps its contents through a clear, so a later load puts the earlier code back.

A mode input decides what the bus pins mean. In serial mode, bus bit 0 carries the serial data and bus bit 1 selects the bit order. The first rank then works as a 16-bit shift register whose outgoing bit appears on a serial output, so several devices can be chained. In byte mode, two active-low lane enables steer the bus byte into the upper or the lower half. The low-lane enable has a second job in both modes: it picks the clear target. The strobe, load and clear inputs are asynchronous. Each one passes through a two-flop synchroniser into the single system clock domain.

Top module: `dac_input_frontend`

## Requirements
- R1: After synchronous reset, the DAC code output is 0x0000, the first-rank register is 0x0000 and the serial output is 0.
- R2: Serial mode (`mode_byte_n` low) with `bus[1]` = 1 loads MSB first. On each chip-select rising edge the first rank shifts toward bit 15 and `bus[0]` enters at bit 0. The serial output shows bit 15 of the first rank.
- R3: Serial mode with `bus[1]` = 0 loads LSB first. On each chip-select rising edge the first rank shifts toward bit 0 and `bus[0]` enters at bit 15. The serial output shows bit 0 of the first rank.
- R4: Byte mode (`mode_byte_n` high). On a chip-select rising edge, `bus[7:0]` is written to bits 15:8 when `hi_lane_n` is low and to bits 7:0 when `lo_lane_n` is low. The halves may be written in either order, or both at once.
- R5: In serial mode the lane enables have no effect on what the first rank captures.
- R6: The DAC register follows the first rank on every clock while the synchronised load is high. It holds its value while load is low. It updates on the third rising clock edge after load rises.
- R7: A synchronised clear sets the DAC register to 0x8000 when `lo_lane_n` is high, and to 0x0000 when it is low, in either mode. The first rank is left unchanged, so a following load restores the previous code.
- R8: When clear and load are both active in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_byte_n | input | 1 | Low: serial loading; high: byte loading |
| strobe | input | 1 | Chip select, acts on its rising edge (asynchronous) |
| bus | input | 8 | Byte data; in serial mode bit 0 is data and bit 1 is order (1 = MSB first) |
| hi_lane_n | input | 1 | Active-low upper-half enable (byte mode only) |
| lo_lane_n | input | 1 | Active-low lower-half enable; clear target (high = bipolar zero) |
| load | input | 1 | Level-sensitive transfer of first rank to DAC register (asynchronous) |
| clear | input | 1 | Forces DAC register to zero code (asynchronous) |
| sdo | output | 1 | Serial output for daisy-chaining |
| dac_code | output | 16 | Code driven to the converter |

## Verification
Clear and load can both be active in the same clock cycle, and the DAC register has to settle that conflict. The bench raises both inputs at the same falling edge, so they leave their synchronisers together. It then expects the clear code, chosen by the level on `lo_lane_n`, to appear on `dac_code`. Clear is then released while load stays high. The code must change to the value in the first rank, which the bench's own model tracks, and that shows the first rank came through the clear untouched.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W = 16;
    localparam int BYTE_W = CODE_W / 2;
    localparam int LANES  = CODE_W / BYTE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_BYTE   = 1'b1
    } mode_t;

    typedef enum logic {
        ORDER_LSB = 1'b0,
        ORDER_MSB = 1'b1
    } order_t;

    // synchronised control strobes, one per clock
    typedef struct packed {
        logic edge_cs;
        logic clear;
        logic load;
    } ctl_t;

    function automatic code_t zero_code(input logic bipolar);
        code_t z;
        z = '0;
        z[CODE_W-1] = bipolar;
        return z;
    endfunction

    function automatic code_t shift_in(input code_t cur, input order_t ord, input logic din);
        if (ord == ORDER_MSB)
            return {cur[CODE_W-2:0], din};
        else
            return {din, cur[CODE_W-1:1]};
    endfunction

    function automatic logic shift_out(input code_t cur, input order_t ord);
        return (ord == ORDER_MSB) ? cur[CODE_W-1] : cur[0];
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dacfe_rank1.sv
module dacfe_rank1
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  edge_cs,
    input  mode_t mode,
    input  byte_t bus,
    input  logic  hi_lane_n,
    input  logic  lo_lane_n,
    output code_t rank1_q,
    output logic  sdo
);
    order_t          ord;
    logic [LANES-1:0] lane_en;
    code_t           nxt;

    assign ord     = order_t'(bus[1]);
    assign lane_en = {~hi_lane_n, ~lo_lane_n};

    always_comb begin
        nxt = rank1_q;
        if (mode == MODE_SERIAL) begin
            nxt = shift_in(rank1_q, ord, bus[0]);
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) nxt[l*BYTE_W +: BYTE_W] = bus;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rank1_q <= '0;
        else if (edge_cs) rank1_q <= nxt;
    end

    assign sdo = (mode == MODE_SERIAL) ? shift_out(rank1_q, ord) : rank1_q[CODE_W-1];

    assert_rank1_reset_R1: assert property (@(posedge clk) rst |=> rank1_q == '0);

    assert_msb_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (edge_cs && mode == MODE_SERIAL && bus[1])
        |=> rank1_q[CODE_W-1:1] == $past(rank1_q[CODE_W-2:0]));

    assert_lsb_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_cs && mode == MODE_SERIAL && !bus[1])
        |=> rank1_q[CODE_W-2:0] == $past(rank1_q[CODE_W-1:1]));

    assert_hi_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (edge_cs && mode == MODE_BYTE && !hi_lane_n)
        |=> rank1_q[CODE_W-1:BYTE_W] == $past(bus));

    assert_lane_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (edge_cs && mode == MODE_BYTE && lo_lane_n)
        |=> $stable(rank1_q[BYTE_W-1:0]));

    assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !edge_cs |=> $stable(rank1_q));
endmodule

// File: rtl/dacfe_rank2.sv
module dacfe_rank2
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  logic  bipolar,
    input  code_t rank1_q,
    output code_t dac_q
);
    always_ff @(posedge clk) begin
        if (rst)            dac_q <= '0;
        else if (ctl.clear) dac_q <= zero_code(bipolar);
        else if (ctl.load)  dac_q <= rank1_q;
    end

    assert_dac_reset_R1: assert property (@(posedge clk) rst |=> dac_q == '0);

    assert_load_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !ctl.clear) |=> dac_q == $past(rank1_q));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.clear) |=> $stable(dac_q));

    assert_clear_value_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (dac_q == ($past(bipolar) ? 16'h8000 : 16'h0000)));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.clear && ctl.load && bipolar) |=> dac_q[CODE_W-2:0] == '0);
endmodule

// File: rtl/dac_input_frontend.sv
module dac_input_frontend
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_byte_n,
    input  logic        strobe,
    input  logic [7:0]  bus,
    input  logic        hi_lane_n,
    input  logic        lo_lane_n,
    input  logic        load,
    input  logic        clear,
    output logic        sdo,
    output logic [15:0] dac_code
);
    logic [2:0] raw_s;
    logic       strobe_prev;
    ctl_t       ctl;
    code_t      rank1_q;
    code_t      dac_q;

    dacfe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strobe, clear, load}),
        .q   (raw_s)
    );

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= raw_s[2];
    end

    assign ctl.edge_cs = raw_s[2] & ~strobe_prev;
    assign ctl.clear   = raw_s[1];
    assign ctl.load    = raw_s[0];

    dacfe_rank1 u_rank1 (
        .clk       (clk),
        .rst       (rst),
        .edge_cs   (ctl.edge_cs),
        .mode      (mode_t'(mode_byte_n)),
        .bus       (bus),
        .hi_lane_n (hi_lane_n),
        .lo_lane_n (lo_lane_n),
        .rank1_q   (rank1_q),
        .sdo       (sdo)
    );

    dacfe_rank2 u_rank2 (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .bipolar (lo_lane_n),
        .rank1_q (rank1_q),
        .dac_q   (dac_q)
    );

    assign dac_code = dac_q;

    assert_single_edge_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.edge_cs |=> !ctl.edge_cs);
endmodule

// File: tb/tb_dac_input_frontend.sv
module tb_dac_input_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_byte_n = 1'b1;
    logic        strobe = 1'b0;
    logic [7:0]  bus = '0;
    logic        hi_lane_n = 1'b1;
    logic        lo_lane_n = 1'b1;
    logic        load = 1'b0;
    logic        clear = 1'b0;
    logic        sdo;
    logic [15:0] dac_code;

    int nvec = 0;
    int nbad = 0;
    logic [15:0] model = '0;

    always #4 clk = ~clk;

    dac_input_frontend dut (
        .clk(clk), .rst(rst), .mode_byte_n(mode_byte_n), .strobe(strobe),
        .bus(bus), .hi_lane_n(hi_lane_n), .lo_lane_n(lo_lane_n),
        .load(load), .clear(clear), .sdo(sdo), .dac_code(dac_code)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1; tick(4);
        strobe = 1'b0; tick(4);
    endtask

    task automatic do_load();
        load = 1'b1; tick(4);
        load = 1'b0; tick(2);
    endtask

    task automatic put_byte(input logic hi, input logic [7:0] v);
        bus = v;
        hi_lane_n = ~hi;
        lo_lane_n = hi;
        pulse_strobe();
        hi_lane_n = 1'b1;
        lo_lane_n = 1'b1;
        if (hi) model[15:8] = v; else model[7:0] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 dac_code", dac_code, 16'h0000);
        chk("R1 sdo", {15'b0, sdo}, 16'h0000);
        do_load();
        chk("R1 rank1 via load", dac_code, 16'h0000);

        // R6 hold: byte writes with load low leave dac_code alone
        mode_byte_n = 1'b1;
        put_byte(1'b1, 8'hAB);
        chk("R6 hold while load low", dac_code, 16'h0000);
        do_load();
        chk("R6 load transfer", dac_code, model);

        // R4 byte sweep, both orders, and both lanes at once
        for (int i = 0; i < 256; i++) begin
            if (i % 16 == 5) begin
                bus = i[7:0]; hi_lane_n = 1'b0; lo_lane_n = 1'b0;
                pulse_strobe();
                hi_lane_n = 1'b1; lo_lane_n = 1'b1;
                model = {i[7:0], i[7:0]};
            end else if (i[0]) begin
                put_byte(1'b0, i[7:0] ^ 8'h5A);
                put_byte(1'b1, i[7:0]);
            end else begin
                put_byte(1'b1, i[7:0]);
                put_byte(1'b0, i[7:0] ^ 8'h5A);
            end
            do_load();
            chk("R4 byte write", dac_code, model);
        end

        // R2/R3/R5 serial words in both orders, lanes toggled
        mode_byte_n = 1'b0;
        for (int w = 0; w < 8; w++) begin
            logic [15:0] word;
            logic        msb;
            word = 16'((w + 1) * 16'h3A71) ^ 16'hC35A;
            msb  = w[0];
            hi_lane_n = ~w[1];
            lo_lane_n = ~w[1];
            for (int b = 0; b < 16; b++) begin
                logic bitv;
                bitv = msb ? word[15 - b] : word[b];
                bus = {b[2:0], w[2:0], msb, bitv};
                tick(1);
                if (msb) chk("R2 sdo msb-first", {15'b0, sdo}, {15'b0, model[15]});
                else     chk("R3 sdo lsb-first", {15'b0, sdo}, {15'b0, model[0]});
                pulse_strobe();
                model = msb ? {model[14:0], bitv} : {bitv, model[15:1]};
            end
            hi_lane_n = 1'b1;
            lo_lane_n = 1'b1;
            do_load();
            if (msb) chk("R2 serial word", dac_code, word);
            else     chk("R3 serial word", dac_code, word);
            chk("R5 lanes ignored in serial", model, word);
        end

        // R7 clear to bipolar then unipolar, rank1 kept
        lo_lane_n = 1'b1;
        clear = 1'b1; tick(4);
        chk("R7 clear bipolar", dac_code, 16'h8000);
        clear = 1'b0; tick(3);
        chk("R7 clear holds", dac_code, 16'h8000);
        do_load();
        chk("R7 reload after clear", dac_code, model);
        lo_lane_n = 1'b0;
        clear = 1'b1; tick(4);
        chk("R7 clear unipolar", dac_code, 16'h0000);
        clear = 1'b0; tick(3);
        lo_lane_n = 1'b1;
        do_load();
        chk("R7 reload after unipolar clear", dac_code, model);

        // R8 clear and load together (byte mode now)
        mode_byte_n = 1'b1;
        put_byte(1'b0, 8'h3C);
        lo_lane_n = 1'b1;
        load = 1'b1; clear = 1'b1; tick(4);
        chk("R8 clear beats load bipolar", dac_code, 16'h8000);
        clear = 1'b0; tick(4);
        chk("R8 load resumes after clear", dac_code, model);
        lo_lane_n = 1'b0;
        clear = 1'b1; tick(4);
        chk("R8 clear beats load unipolar", dac_code, 16'h0000);
        clear = 1'b0; lo_lane_n = 1'b1; tick(4);
        chk("R8 load resumes unipolar case", dac_code, model);

        // R6 level: while load stays high, dac_code follows new writes
        put_byte(1'b1, 8'hE7);
        chk("R6 follows while high", dac_code, model);
        load = 1'b0; tick(3);
        put_byte(1'b1, 8'h11);
        chk("R6 hold after load falls", dac_code, {8'hE7, model[7:0]});

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule